// File: doc/BRIEF.md
# Watchdog Timer with Postscaler

This block is a watchdog for a small microcontroller. A slow oscillator pulse (`osc_tick`) first passes through a fixed prescaler of `PRE_DIV` pulses, which sets the base watchdog period. A 16-stage postscaler then stretches that base period by a power of two from 1 to 32,768, chosen by a 4-bit period field. With the default `PRE_DIV` of 128 and a nominal base period of 4 ms, the timeout range is 4 ms to 131.072 s. The prescaler length is a parameter, so a simulation build can shorten it and still reach every tap.

The watchdog runs when either the configuration enable or the software enable is set. The software enable sits in bit 0 of an 8-bit control register, and the configuration enable overrides it. Three one-cycle pulses restart the count from zero: the clear-watchdog instruction, entry into sleep, and a flagged oscillator failure. When the count expires, the block gives a one-cycle reset request if the core is awake, or a one-cycle wake-up pulse if the core is asleep. It also sets a sticky time-out flag and starts counting again from zero.

Top module: `wdog_core`

## Requirements
- R1: After reset, `reg_rdata` is 0, `to_flag` is 0, and `wdt_reset` and `wdt_wake` are both 0.
- R2: After the counts are cleared with period field value s (0 to 15), the timeout pulse appears exactly `PRE_DIV * 2**s` `osc_tick` pulses later. It is visible in the cycle after the clock edge that samples the last of those pulses.
- R3: While `cfg_en` and the software enable are both 0, no timeout pulse occurs and the counts stay at zero.
- R4: Writing 1 to control bit 0 starts the watchdog when `cfg_en` is 0. While `cfg_en` is 1, writing 0 to that bit does not stop the watchdog.
- R5: A write to `reg_wdata` stores only bit 0. `reg_rdata` returns that bit in position 0, and bits 7 to 1 always read 0.
- R6: A pulse on `clrwdt`, `sleep_enter` or `clk_fail` clears both counts. The next timeout then comes a full period after that pulse.
- R7: A timeout while `asleep` is 1 raises `wdt_wake` and not `wdt_reset`. A timeout while `asleep` is 0 raises `wdt_reset` and not `wdt_wake`.
- R8: Each timeout pulse lasts one cycle. The counts restart from zero, so without a clear the next pulse follows one full period later.
- R9: `to_flag` sets on any timeout, stays set, and clears on `clrwdt` or power-on reset.
- R10: The period field is sampled only while both counts are zero. A change made during a count takes effect from the next count.
- R11: `osc_run` equals `cfg_en` OR the software enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| osc_tick | input | 1 | One-cycle pulse per slow oscillator period |
| cfg_en | input | 1 | Configuration enable; overrides the software enable |
| cfg_period | input | 4 | Postscaler period field, ratio 2**value |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Control register write data; bit 0 is the software enable |
| reg_rdata | output | 8 | Control register read data |
| clrwdt | input | 1 | Clear-watchdog instruction pulse |
| sleep_enter | input | 1 | Sleep entry pulse |
| clk_fail | input | 1 | Oscillator failure pulse |
| asleep | input | 1 | Core is in sleep or another power-managed mode |
| osc_run | output | 1 | Request to run the slow oscillator |
| wdt_reset | output | 1 | One-cycle device reset request |
| wdt_wake | output | 1 | One-cycle wake-up pulse |
| to_flag | output | 1 | Sticky time-out status |

## Verification
The assertions assume three things about the inputs: `asleep` does not change in the cycle that a timeout is sampled, the three clear pulses are single-cycle, and `cfg_period` stays below 16. The stimulus changes `asleep` only between measured periods. It drives each clear source for exactly one cycle and sweeps the period field only over its legal values. With `osc_tick` held high, every expected period is a plain product that the bench computes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int unsigned REG_W = 8;

   typedef struct packed {
      logic insn;
      logic sleep;
      logic osc_fail;
   } clr_src_t;

   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_RESET = 2'd1,
      ACT_WAKE  = 2'd2
   } act_e;

   function automatic logic any_clear(input clr_src_t s);
      return s.insn | s.sleep | s.osc_fail;
   endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int unsigned PRE_DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   output logic base_tick,
   output logic idle
);
   localparam int unsigned CW   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
   localparam bit          POW2 = ((1 << CW) == PRE_DIV);
   localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

   if (PRE_DIV < 2) begin : g_bad_div
      $error("wdog_prescale: PRE_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          last;

   assign last      = (cnt == LAST);
   assign base_tick = tick & ~hold & last;
   assign idle      = (cnt == '0);

   if (POW2) begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (hold) cnt <= '0;
         else if (tick) cnt <= cnt + CW'(1);
      end
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (hold) cnt <= '0;
         else if (tick) cnt <= last ? '0 : cnt + CW'(1);
      end
   end

   p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> idle);

endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
   parameter int unsigned POST_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        base_tick,
   input  logic                        hold,
   input  logic                        pre_idle,
   input  logic [$clog2(POST_W)-1:0]   period,
   output logic                        hit
);
   localparam int unsigned SEL_W = $clog2(POST_W);

   if ((1 << SEL_W) != POST_W) begin : g_bad_w
      $error("wdog_postscale: POST_W must be a power of two");
   end

   logic [POST_W-1:0] cnt;
   logic [SEL_W-1:0]  sel_q;
   logic [POST_W-1:0] terminal;
   logic              at_zero;

   assign terminal = (POST_W'(1) << sel_q) - POST_W'(1);
   assign at_zero  = pre_idle & (cnt == '0);
   assign hit      = base_tick & (cnt == terminal);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel_q <= '0;
      else if (at_zero) sel_q <= period;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (hold || hit)   cnt <= '0;
      else if (base_tick)     cnt <= cnt + POST_W'(1);
   end

   p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_q) |-> $past(at_zero));

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= terminal);

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs import wdog_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             clr_insn,
   input  logic             timeout,
   output logic             sw_en,
   output logic             to_flag,
   output logic [REG_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sw_en <= 1'b0;
      else if (wr) sw_en <= wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        to_flag <= 1'b0;
      else if (clr_insn) to_flag <= 1'b0;
      else if (timeout)  to_flag <= 1'b1;
   end

   assign rdata = {{(REG_W-1){1'b0}}, sw_en};

   p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_insn |=> !to_flag);

   p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !clr_insn) |=> to_flag);

endmodule

// File: rtl/wdog_core.sv
module wdog_core import wdog_pkg::*; #(
   parameter int unsigned PRE_DIV = 128,
   parameter int unsigned POST_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             cfg_en,
   input  logic [3:0]       cfg_period,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             clrwdt,
   input  logic             sleep_enter,
   input  logic             clk_fail,
   input  logic             asleep,
   output logic             osc_run,
   output logic             wdt_reset,
   output logic             wdt_wake,
   output logic             to_flag
);
   localparam int unsigned SEL_W = $clog2(POST_W);

   if (SEL_W != 4) begin : g_bad_sel
      $error("wdog_core: period field is 4 bits, POST_W must be 16");
   end

   clr_src_t clr_src;
   logic     clear_any;
   logic     sw_en;
   logic     hold;
   logic     base_tick;
   logic     pre_idle;
   logic     hit;
   act_e     act_q;

   assign clr_src   = '{insn: clrwdt, sleep: sleep_enter, osc_fail: clk_fail};
   assign clear_any = any_clear(clr_src);
   assign osc_run   = cfg_en | sw_en;
   assign hold      = clear_any | ~osc_run;

   wdog_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (osc_tick),
      .hold      (hold),
      .base_tick (base_tick),
      .idle      (pre_idle)
   );

   wdog_postscale #(.POST_W(POST_W)) u_post (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .hold      (hold),
      .pre_idle  (pre_idle),
      .period    (SEL_W'(cfg_period)),
      .hit       (hit)
   );

   wdog_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .clr_insn (clrwdt),
      .timeout  (hit),
      .sw_en    (sw_en),
      .to_flag  (to_flag),
      .rdata    (reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q <= ACT_IDLE;
      else if (!hit)   act_q <= ACT_IDLE;
      else if (asleep) act_q <= ACT_WAKE;
      else             act_q <= ACT_RESET;
   end

   assign wdt_reset = (act_q == ACT_RESET);
   assign wdt_wake  = (act_q == ACT_WAKE);

   p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_reset || wdt_wake) |=> !(wdt_reset || wdt_wake));

   p_wake_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_wake |-> $past(asleep));

   p_reset_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |-> !$past(asleep));

   p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_run |=> !(wdt_reset || wdt_wake));

   p_flag_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_reset || wdt_wake) |-> to_flag);

endmodule

// File: tb/wdog_core_test.sv
module wdog_core_test;
   localparam int unsigned PRE = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b1;
   logic       cfg_en = 1'b0;
   logic [3:0] cfg_period = 4'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       clrwdt = 1'b0;
   logic       sleep_enter = 1'b0;
   logic       clk_fail = 1'b0;
   logic       asleep = 1'b0;
   logic       osc_run, wdt_reset, wdt_wake, to_flag;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   wdog_core #(.PRE_DIV(PRE), .POST_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cfg_en(cfg_en),
      .cfg_period(cfg_period), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .clrwdt(clrwdt), .sleep_enter(sleep_enter),
      .clk_fail(clk_fail), .asleep(asleep), .osc_run(osc_run),
      .wdt_reset(wdt_reset), .wdt_wake(wdt_wake), .to_flag(to_flag)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_reg(input logic [7:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic start_clear(input int sel);
      cfg_period = 4'(sel);
      clrwdt = 1'b1;
      tick();
      clrwdt = 1'b0;
   endtask

   task automatic count_pulse(input int limit, output int n, output bit rs, output bit wk);
      n = 0; rs = 0; wk = 0;
      while (n < limit) begin
         tick();
         n++;
         if (wdt_reset || wdt_wake) begin
            rs = wdt_reset; wk = wdt_wake;
            break;
         end
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int  n;
      bit  rs, wk;
      int  quiet;

      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(reg_rdata == 8'd0, "R1 rdata", reg_rdata, 0);
      chk(to_flag == 1'b0, "R1 flag", to_flag, 0);
      chk(!wdt_reset && !wdt_wake, "R1 pulses", {wdt_reset, wdt_wake}, 0);
      chk(osc_run == 1'b0, "R11 off", osc_run, 0);

      // R3 disabled: no pulse
      quiet = 0;
      for (int i = 0; i < 60; i++) begin
         tick();
         if (wdt_reset || wdt_wake) quiet++;
      end
      chk(quiet == 0, "R3 disabled quiet", quiet, 0);

      // R5 only bit 0 stored
      write_reg(8'hFF);
      chk(reg_rdata == 8'h01, "R5 readback", reg_rdata, 1);
      chk(osc_run == 1'b1, "R11 sw on", osc_run, 1);

      // R4 software enable runs the watchdog
      start_clear(2);
      count_pulse(100, n, rs, wk);
      chk(n == PRE * 4, "R4 sw enable period", n, PRE * 4);
      chk(rs && !wk, "R7 awake gives reset", {rs, wk}, 2);
      chk(to_flag == 1'b1, "R9 flag set", to_flag, 1);

      // R8 single cycle and restart
      tick();
      chk(!wdt_reset, "R8 one cycle", wdt_reset, 0);
      chk(to_flag == 1'b1, "R9 flag sticky", to_flag, 1);
      count_pulse(100, n, rs, wk);
      chk(n + 1 == PRE * 4, "R8 restart period", n + 1, PRE * 4);

      // R9 clear instruction drops the flag
      clrwdt = 1'b1; tick(); clrwdt = 1'b0;
      chk(to_flag == 1'b0, "R9 flag cleared", to_flag, 0);

      // R2 sweep every tap, config enable on as well
      cfg_en = 1'b1;
      for (int s = 0; s < 16; s++) begin
         start_clear(s);
         count_pulse((PRE << 15) + 8, n, rs, wk);
         chk(n == (PRE << s), $sformatf("R2 tap %0d", s), n, PRE << s);
      end

      // R4 config enable overrides a software disable
      write_reg(8'h00);
      chk(reg_rdata == 8'h00, "R5 readback zero", reg_rdata, 0);
      chk(osc_run == 1'b1, "R11 cfg on", osc_run, 1);
      start_clear(1);
      count_pulse(100, n, rs, wk);
      chk(n == PRE * 2, "R4 cfg overrides", n, PRE * 2);

      // R6 each clear source restarts the count
      for (int src = 0; src < 3; src++) begin
         start_clear(3);
         repeat (10) tick();
         clrwdt = (src == 0); sleep_enter = (src == 1); clk_fail = (src == 2);
         tick();
         clrwdt = 1'b0; sleep_enter = 1'b0; clk_fail = 1'b0;
         count_pulse(200, n, rs, wk);
         chk(n == PRE * 8, $sformatf("R6 source %0d", src), n, PRE * 8);
      end

      // R7 asleep gives wake
      asleep = 1'b1;
      start_clear(2);
      count_pulse(100, n, rs, wk);
      chk(wk && !rs, "R7 asleep gives wake", {rs, wk}, 1);
      chk(n == PRE * 4, "R7 wake period", n, PRE * 4);
      asleep = 1'b0;

      // R10 period change mid count
      start_clear(2);
      repeat (3) tick();
      cfg_period = 4'd5;
      count_pulse(200, n, rs, wk);
      chk(n + 3 == PRE * 4, "R10 old period kept", n + 3, PRE * 4);
      count_pulse(400, n, rs, wk);
      chk(n == PRE * 32, "R10 new period next", n, PRE * 32);

      // R3 disable mid count
      start_clear(3);
      repeat (5) tick();
      cfg_en = 1'b0;
      tick();
      chk(osc_run == 1'b0, "R11 both off", osc_run, 0);
      quiet = 0;
      for (int i = 0; i < 100; i++) begin
         tick();
         if (wdt_reset || wdt_wake) quiet++;
      end
      chk(quiet == 0, "R3 stopped", quiet, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule